// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

A three-stage pipelined multiplier for IEEE-754 binary32 operands. Each clock cycle it can accept one operation: two 32-bit operands, a rounding mode, a guard bit and a flags-only select. Exactly three cycles later it presents the rounded product and a six-bit exception vector. Subnormal numbers are never consumed or produced. A subnormal operand is read as zero and raises an input-flush flag. A product that would land in the subnormal range is replaced by a signed zero and raises an output-flush flag.

The block is meant to sit beside a register file and a sticky status register, which is a separate block. `out_wr` is the destination write enable. `out_flag_en` tells the status register to OR `out_flags` into its contents. A false guard suppresses both. A flags-only operation asserts `out_flag_en` but not `out_wr`, so software can learn which exceptions a multiply would raise without writing a result. Issue is a plain valid strobe with no ready signal. The pipeline never stalls and applies no back-pressure, so every accepted operation is retired three cycles later whatever the consumer does.

Flag vector bit positions: bit 0 invalid, bit 1 overflow, bit 2 underflow, bit 3 inexact, bit 4 input flushed, bit 5 output flushed.

Top module: `spfp_mul`

## Requirements
- R1: An operation sampled at a rising edge with `in_valid`=1 is reflected on the outputs after the third rising edge, counting the sampling edge as the first. A new operation may be issued on every edge.
- R2: Finite normal products are rounded by `in_rmode`: 00 nearest-even, 01 toward +INF, 10 toward -INF, 11 toward zero. Inexact (bit 3) is raised when any product bits are discarded.
- R3: On overflow, overflow (bit 1) and inexact (bit 3) are raised. The result is a signed infinity under nearest-even, and under a directed mode that rounds away from zero for that sign. Otherwise it is the signed largest finite value 0x7F7FFFFF.
- R4: An operand with exponent field 0 and a nonzero fraction is read as zero, and input-flush (bit 4) is raised.
- R5: When the exponent after rounding lies in the subnormal band (biased value -22 to 0), the result is a zero with sign a XOR b, and output-flush (bit 5), underflow (bit 2) and inexact (bit 3) are raised.
- R6: When the exponent after rounding is below -22, the result is a zero with sign a XOR b, only underflow and inexact are raised, and output-flush stays 0.
- R7: A NaN operand gives 0xFFFFFFFF. Invalid (bit 0) is raised only if an operand is a signaling NaN, meaning fraction MSB 0.
- R8: Infinity times zero, where zero includes a flushed subnormal, gives 0xFFFFFFFF and raises invalid.
- R9: Infinity times a nonzero non-NaN gives an infinity, and zero times a finite value gives a zero, both with no exception flags. The result sign is always a XOR b.
- R10: With guard 0, the operation gives `out_wr`=0, `out_flag_en`=0, and `out_prod` and `out_flags` all zero.
- R11: A flags-only operation with guard 1 gives `out_flag_en`=1, `out_wr`=0 and `out_prod`=0, with the same flags a normal multiply would raise.
- R12: During and right after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue strobe |
| in_guard | input | 1 | Guard; 0 suppresses the write and the flag update |
| in_flags_only | input | 1 | Report flags only, no destination write |
| in_rmode | input | 2 | Rounding mode (see R2) |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_wr | output | 1 | Destination write enable |
| out_flag_en | output | 1 | Flag update enable for the status register |
| out_prod | output | 32 | Product (zero when `out_wr`=0) |
| out_flags | output | 6 | Exception flags (zero when `out_flag_en`=0) |

## Verification
Input flushing and a special-case result can fall in the same retired operation. The bench provokes this with infinity times a subnormal, which must return the quiet NaN with invalid and input-flush both set. A second collision is a flags-only operation issued on the edge right after a writing multiply. This checks that the two enables separate cleanly in adjacent output cycles and that the flags of both operations are correct. A scoreboard holds one expected item per issued cycle and compares each item against the outputs three cycles later.

// File: rtl/spfp_pkg.sv
`timescale 1ns/1ps
package spfp_pkg;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int WORD_W   = 1 + EXP_W + FRAC_W;
  localparam int MANT_W   = FRAC_W + 1;
  localparam int PROD_W   = 2 * MANT_W;
  localparam int EXPI_W   = EXP_W + 2;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_ALL1 = (1 << EXP_W) - 1;
  localparam int FLAG_W   = 6;

  localparam int F_INV = 0;
  localparam int F_OVF = 1;
  localparam int F_UNF = 2;
  localparam int F_INX = 3;
  localparam int F_IFZ = 4;
  localparam int F_OFZ = 5;

  localparam logic [WORD_W-1:0] QNAN_WORD = '1;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic   valid;
    logic   guard;
    logic   fonly;
    rmode_e rmode;
    logic   sign;
  } ctl_t;

  typedef struct packed {
    ctl_t                     ctl;
    logic                     special;
    logic [WORD_W-1:0]        spec_res;
    logic [FLAG_W-1:0]        spec_flags;
    logic                     iflush;
    logic signed [EXPI_W-1:0] exp;
    logic [MANT_W-1:0]        ma;
    logic [MANT_W-1:0]        mb;
  } s1_t;

  typedef struct packed {
    ctl_t                     ctl;
    logic                     special;
    logic [WORD_W-1:0]        spec_res;
    logic [FLAG_W-1:0]        spec_flags;
    logic                     iflush;
    logic signed [EXPI_W-1:0] exp;
    logic [PROD_W-1:0]        prod;
  } s2_t;
endpackage

// File: rtl/fpm_classify.sv
`timescale 1ns/1ps
module fpm_classify
  import spfp_pkg::*;
(
  input  logic [WORD_W-1:0] op,
  output logic              sign,
  output logic              zero,
  output logic              denorm,
  output logic              inf,
  output logic              nan,
  output logic              snan,
  output logic [EXP_W-1:0]  exp,
  output logic [MANT_W-1:0] mant
);
  logic [FRAC_W-1:0] frac;
  logic exp_zero, exp_ones, frac_nz;

  assign sign     = op[WORD_W-1];
  assign exp      = op[WORD_W-2 -: EXP_W];
  assign frac     = op[FRAC_W-1:0];
  assign exp_zero = (exp == '0);
  assign exp_ones = (exp == '1);
  assign frac_nz  = |frac;

  // a subnormal counts as zero from here on
  assign zero   = exp_zero;
  assign denorm = exp_zero & frac_nz;
  assign inf    = exp_ones & ~frac_nz;
  assign nan    = exp_ones & frac_nz;
  assign snan   = nan & ~frac[FRAC_W-1];
  assign mant   = {1'b1, frac};
endmodule

// File: rtl/fpm_unpack.sv
`timescale 1ns/1ps
module fpm_unpack
  import spfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_guard,
  input  logic              in_fonly,
  input  logic [1:0]        in_rmode,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output s1_t               s1_q
);
  localparam int N_OP = 2;

  logic [WORD_W-1:0] ops      [N_OP];
  logic [N_OP-1:0]   c_sign, c_zero, c_denorm, c_inf, c_nan, c_snan;
  logic [EXP_W-1:0]  c_exp    [N_OP];
  logic [MANT_W-1:0] c_mant   [N_OP];
  s1_t               nxt;

  assign ops[0] = in_a;
  assign ops[1] = in_b;

  for (genvar i = 0; i < N_OP; i++) begin : g_op
    fpm_classify u_cls (
      .op    (ops[i]),
      .sign  (c_sign[i]),
      .zero  (c_zero[i]),
      .denorm(c_denorm[i]),
      .inf   (c_inf[i]),
      .nan   (c_nan[i]),
      .snan  (c_snan[i]),
      .exp   (c_exp[i]),
      .mant  (c_mant[i])
    );
  end

  always_comb begin
    nxt           = '0;
    nxt.ctl.valid = in_valid;
    nxt.ctl.guard = in_guard;
    nxt.ctl.fonly = in_fonly;
    nxt.ctl.rmode = rmode_e'(in_rmode);
    nxt.ctl.sign  = ^c_sign;
    nxt.iflush    = |c_denorm;
    nxt.exp       = $signed({2'b00, c_exp[0]}) + $signed({2'b00, c_exp[1]})
                    - EXPI_W'(BIAS);
    nxt.ma        = c_mant[0];
    nxt.mb        = c_mant[1];
    if (|c_nan) begin
      nxt.special           = 1'b1;
      nxt.spec_res          = QNAN_WORD;
      nxt.spec_flags[F_INV] = |c_snan;
    end else if ((|c_inf) && (|c_zero)) begin
      nxt.special           = 1'b1;
      nxt.spec_res          = QNAN_WORD;
      nxt.spec_flags[F_INV] = 1'b1;
    end else if (|c_inf) begin
      nxt.special  = 1'b1;
      nxt.spec_res = {nxt.ctl.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (|c_zero) begin
      nxt.special  = 1'b1;
      nxt.spec_res = {nxt.ctl.sign, {(WORD_W-1){1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s1_q <= '0;
    else        s1_q <= nxt;
  end

  // R4: a subnormal operand reaches the next stage marked as flushed
  p_iflush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_a[WORD_W-2 -: EXP_W] == '0 && in_a[FRAC_W-1:0] != '0)
      |=> s1_q.iflush);
endmodule

// File: rtl/fpm_mantmul.sv
`timescale 1ns/1ps
module fpm_mantmul
  import spfp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  s1_t  s1_q,
  output s2_t  s2_q
);
  s2_t nxt;

  always_comb begin
    nxt            = '0;
    nxt.ctl        = s1_q.ctl;
    nxt.special    = s1_q.special;
    nxt.spec_res   = s1_q.spec_res;
    nxt.spec_flags = s1_q.spec_flags;
    nxt.iflush     = s1_q.iflush;
    nxt.exp        = s1_q.exp;
    nxt.prod       = PROD_W'(s1_q.ma) * PROD_W'(s1_q.mb);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) s2_q <= '0;
    else        s2_q <= nxt;
  end
endmodule

// File: rtl/fpm_round.sv
`timescale 1ns/1ps
module fpm_round
  import spfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  s2_t               s2_q,
  output logic              out_wr,
  output logic              out_fen,
  output logic [WORD_W-1:0] out_prod,
  output logic [FLAG_W-1:0] out_flags
);
  localparam logic signed [EXPI_W-1:0] EXP_OVF    = EXPI_W'(EXP_ALL1);
  localparam logic signed [EXPI_W-1:0] EXP_NORM   = EXPI_W'(1);
  localparam logic signed [EXPI_W-1:0] EXP_SUB_LO = EXPI_W'(1 - FRAC_W);

  logic [PROD_W-1:0]        norm;
  logic signed [EXPI_W-1:0] expn, expr;
  logic [MANT_W-1:0]        mant;
  logic                     g_bit, st_bit, inc, sgn, to_inf;
  logic [MANT_W:0]          mant_r;
  logic [WORD_W-1:0]        res;
  logic [FLAG_W-1:0]        flags;
  logic                     wr_d, fen_d;

  assign sgn = s2_q.ctl.sign;

  always_comb begin
    norm   = s2_q.prod[PROD_W-1] ? s2_q.prod : (s2_q.prod << 1);
    expn   = s2_q.exp + $signed({{(EXPI_W-1){1'b0}}, s2_q.prod[PROD_W-1]});
    mant   = norm[PROD_W-1 -: MANT_W];
    g_bit  = norm[PROD_W-MANT_W-1];
    st_bit = |norm[PROD_W-MANT_W-2:0];
    unique case (s2_q.ctl.rmode)
      RM_NEAR: inc = g_bit & (st_bit | mant[0]);
      RM_UP:   inc = ~sgn & (g_bit | st_bit);
      RM_DOWN: inc = sgn & (g_bit | st_bit);
      default: inc = 1'b0;
    endcase
    to_inf = (s2_q.ctl.rmode == RM_NEAR) ||
             (s2_q.ctl.rmode == RM_UP   && !sgn) ||
             (s2_q.ctl.rmode == RM_DOWN &&  sgn);
    mant_r = {1'b0, mant} + {{MANT_W{1'b0}}, inc};
    expr   = expn + $signed({{(EXPI_W-1){1'b0}}, mant_r[MANT_W]});
    flags  = '0;
    res    = '0;
    if (s2_q.special) begin
      res   = s2_q.spec_res;
      flags = s2_q.spec_flags;
    end else if (expr >= EXP_OVF) begin
      flags[F_OVF] = 1'b1;
      flags[F_INX] = 1'b1;
      res = to_inf ? {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                   : {sgn, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
    end else if (expr >= EXP_NORM) begin
      flags[F_INX] = g_bit | st_bit;
      res = {sgn, expr[EXP_W-1:0], mant_r[FRAC_W-1:0]};
    end else begin
      flags[F_UNF] = 1'b1;
      flags[F_INX] = 1'b1;
      flags[F_OFZ] = (expr >= EXP_SUB_LO);
      res = {sgn, {(WORD_W-1){1'b0}}};
    end
    flags[F_IFZ] = s2_q.iflush;
    fen_d = s2_q.ctl.valid & s2_q.ctl.guard;
    wr_d  = fen_d & ~s2_q.ctl.fonly;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_wr    <= 1'b0;
      out_fen   <= 1'b0;
      out_prod  <= '0;
      out_flags <= '0;
    end else begin
      out_wr    <= wr_d;
      out_fen   <= fen_d;
      out_prod  <= wr_d ? res : '0;
      out_flags <= fen_d ? flags : '0;
    end
  end

  p_ovf_inx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_flags[F_OVF] |-> out_flags[F_INX]);
  p_ofz_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_flags[F_OFZ] |-> (out_flags[F_UNF] && out_flags[F_INX] &&
                          out_prod[WORD_W-2:0] == '0));
  p_unf_no_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_flags[F_UNF] |-> !out_flags[F_OVF]);
  p_inv_nan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wr && out_flags[F_INV]) |-> out_prod == QNAN_WORD);
  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_fen |-> (out_flags == '0 && !out_wr && out_prod == '0));
endmodule

// File: rtl/spfp_mul.sv
`timescale 1ns/1ps
module spfp_mul
  import spfp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_guard,
  input  logic        in_flags_only,
  input  logic [1:0]  in_rmode,
  input  logic [31:0] in_a,
  input  logic [31:0] in_b,
  output logic        out_wr,
  output logic        out_flag_en,
  output logic [31:0] out_prod,
  output logic [5:0]  out_flags
);
  s1_t s1_q;
  s2_t s2_q;

  fpm_unpack u_unpack (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_guard(in_guard),
    .in_fonly(in_flags_only),
    .in_rmode(in_rmode),
    .in_a    (in_a),
    .in_b    (in_b),
    .s1_q    (s1_q)
  );

  fpm_mantmul u_mul (
    .clk  (clk),
    .rst_n(rst_n),
    .s1_q (s1_q),
    .s2_q (s2_q)
  );

  fpm_round u_round (
    .clk      (clk),
    .rst_n    (rst_n),
    .s2_q     (s2_q),
    .out_wr   (out_wr),
    .out_fen  (out_flag_en),
    .out_prod (out_prod),
    .out_flags(out_flags)
  );

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_guard && !in_flags_only) |-> ##3 out_wr);
  p_fonly_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_guard && in_flags_only) |-> ##3
      (out_flag_en && !out_wr && out_prod == '0));
  p_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || !in_guard) |-> ##3 (!out_flag_en && !out_wr));
endmodule

// File: tb/spfp_mul_test.sv
`timescale 1ns/1ps
module spfp_mul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_guard = 1'b0, in_flags_only = 1'b0;
  logic [1:0]  in_rmode = 2'b00;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_wr, out_flag_en;
  logic [31:0] out_prod;
  logic [5:0]  out_flags;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        wr;
    logic        fen;
    logic [31:0] prod;
    logic [5:0]  flags;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  // flag encodings (bit positions from the requirements)
  localparam logic [5:0] INV = 6'h01, OVF = 6'h02, UNF = 6'h04,
                         INX = 6'h08, IFZ = 6'h10, OFZ = 6'h20;
  localparam logic [1:0] NEAR = 2'b00, UP = 2'b01, DOWN = 2'b10, TZ = 2'b11;

  always #5 clk = ~clk;

  spfp_mul uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_guard(in_guard),
    .in_flags_only(in_flags_only), .in_rmode(in_rmode), .in_a(in_a), .in_b(in_b),
    .out_wr(out_wr), .out_flag_en(out_flag_en), .out_prod(out_prod),
    .out_flags(out_flags)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic issue(input string tag, input logic g, input logic fo,
                       input logic [1:0] rm, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] ep,
                       input logic [5:0] ef);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_guard = g; in_flags_only = fo;
    in_rmode = rm; in_a = a; in_b = b;
    e.wr = g & ~fo;
    e.fen = g;
    e.prod = (g & ~fo) ? ep : 32'h0;
    e.flags = g ? ef : 6'h0;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle();
    exp_t e;
    @(negedge clk);
    in_valid = 1'b0; in_guard = 1'b0; in_flags_only = 1'b0;
    in_a = '0; in_b = '0;
    e.wr = 1'b0; e.fen = 1'b0; e.prod = '0; e.flags = '0; e.tag = "R1 idle";
    sbq.push_back(e);
  endtask

  // monitor: the item issued before edge e is visible after edge e+2
  always @(posedge clk) begin
    #2;
    if (rst_n && sbq.size() >= 3) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (out_wr !== e.wr || out_flag_en !== e.fen ||
          out_prod !== e.prod || out_flags !== e.flags) begin
        errors++;
        $display("FAIL %s: got wr=%b fen=%b prod=%h flags=%h, expected wr=%b fen=%b prod=%h flags=%h",
                 e.tag, out_wr, out_flag_en, out_prod, out_flags,
                 e.wr, e.fen, e.prod, e.flags);
      end
    end
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_wr !== 1'b0 || out_flag_en !== 1'b0 || out_prod !== '0 || out_flags !== '0) begin
      errors++;
      $display("FAIL R12 reset: got wr=%b fen=%b prod=%h flags=%h, expected all zero",
               out_wr, out_flag_en, out_prod, out_flags);
    end
    rst_n = 1'b1;

    // R2 exact products, back-to-back (R1)
    issue("R2 -3*1",         1, 0, NEAR, 32'hC0400000, 32'h3F800000, 32'hC0400000, 6'h00);
    issue("R1 R2 3*-3",      1, 0, NEAR, 32'h40400000, 32'hC0400000, 32'hC1100000, 6'h00);
    issue("R2 3*minnorm",    1, 0, NEAR, 32'h40400000, 32'h00800000, 32'h01400000, 6'h00);
    // R2 rounding modes on (1+2^-23)^2
    issue("R2 near",         1, 0, NEAR, 32'h3F800001, 32'h3F800001, 32'h3F800002, INX);
    issue("R2 up",           1, 0, UP,   32'h3F800001, 32'h3F800001, 32'h3F800003, INX);
    issue("R2 down pos",     1, 0, DOWN, 32'h3F800001, 32'h3F800001, 32'h3F800002, INX);
    issue("R2 zero",         1, 0, TZ,   32'h3F800001, 32'h3F800001, 32'h3F800002, INX);
    issue("R2 down neg",     1, 0, DOWN, 32'hBF800001, 32'h3F800001, 32'hBF800003, INX);
    issue("R2 up neg",       1, 0, UP,   32'hBF800001, 32'h3F800001, 32'hBF800002, INX);
    // R2 ties to even
    issue("R2 tie odd up",   1, 0, NEAR, 32'h3FC00000, 32'h3F800001, 32'h3FC00002, INX);
    issue("R2 tie even",     1, 0, NEAR, 32'h3FC00000, 32'h3F800003, 32'h3FC00004, INX);
    issue("R2 tie trunc",    1, 0, TZ,   32'h3FC00000, 32'h3F800001, 32'h3FC00001, INX);
    // R3 overflow
    issue("R3 ovf near",     1, 0, NEAR, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, OVF|INX);
    issue("R3 ovf zero",     1, 0, TZ,   32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F7FFFFF, OVF|INX);
    issue("R3 ovf up pos",   1, 0, UP,   32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, OVF|INX);
    issue("R3 ovf down pos", 1, 0, DOWN, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F7FFFFF, OVF|INX);
    issue("R3 ovf down neg", 1, 0, DOWN, 32'hFF7FFFFF, 32'h7F7FFFFF, 32'hFF800000, OVF|INX);
    issue("R3 ovf up neg",   1, 0, UP,   32'hFF7FFFFF, 32'h7F7FFFFF, 32'hFF7FFFFF, OVF|INX);
    // R4 subnormal operand
    issue("R4 iflush",       1, 0, NEAR, 32'h40400000, 32'h00400000, 32'h00000000, IFZ);
    issue("R4 iflush neg",   1, 0, NEAR, 32'hC0400000, 32'h00000001, 32'h80000000, IFZ);
    // R5 / R6 tiny results
    issue("R5 ofz",          1, 0, NEAR, 32'h3F000000, 32'h00800000, 32'h00000000, OFZ|UNF|INX);
    issue("R6 far neg",      1, 0, NEAR, 32'h00C00000, 32'h80800000, 32'h80000000, UNF|INX);
    issue("R6 far minsq",    1, 0, NEAR, 32'h00800000, 32'h00800000, 32'h00000000, UNF|INX);
    // R7 / R8 / R9 specials
    issue("R7 qnan",         1, 0, NEAR, 32'h7FC00000, 32'h3F800000, 32'hFFFFFFFF, 6'h00);
    issue("R7 snan",         1, 0, NEAR, 32'h3F800000, 32'h7F800001, 32'hFFFFFFFF, INV);
    issue("R8 inf*0",        1, 0, NEAR, 32'h7F800000, 32'h00000000, 32'hFFFFFFFF, INV);
    issue("R8 R4 inf*sub",   1, 0, NEAR, 32'h7F800000, 32'h00000001, 32'hFFFFFFFF, INV|IFZ);
    issue("R9 inf*-inf",     1, 0, NEAR, 32'h7F800000, 32'hFF800000, 32'hFF800000, 6'h00);
    issue("R9 inf*-3",       1, 0, NEAR, 32'h7F800000, 32'hC0400000, 32'hFF800000, 6'h00);
    issue("R9 0*-3",         1, 0, NEAR, 32'h00000000, 32'hC0400000, 32'h80000000, 6'h00);
    // R10 guard off, R11 flags only adjacent to writes
    issue("R10 guard off",   0, 0, NEAR, 32'h40400000, 32'h00800000, 32'h01400000, 6'h00);
    issue("R10 guard off ovf", 0, 0, NEAR, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, OVF|INX);
    issue("R11 R1 write",    1, 0, NEAR, 32'h40400000, 32'hC0400000, 32'hC1100000, 6'h00);
    issue("R11 fonly ofz",   1, 1, NEAR, 32'h3F000000, 32'h00800000, 32'h00000000, OFZ|UNF|INX);
    issue("R11 fonly ovf",   1, 1, NEAR, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, OVF|INX);
    issue("R11 fonly guard off", 0, 1, NEAR, 32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, OVF|INX);
    idle();
    issue("R1 after gap",    1, 0, NEAR, 32'h3F800000, 32'h3F800000, 32'h3F800000, 6'h00);
    repeat (4) idle();
    @(negedge clk);
    summary();
    $finish;
  end
endmodule